// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block connects a clocked request port to an asynchronous, byte-wide static RAM that has active-low chip-enable, output-enable and write-enable pins. Each accepted request becomes one complete memory cycle on the pins. A write asserts chip enable and write enable together for a set number of clocks while output enable stays high. A read asserts chip enable and output enable for a set number of clocks and then captures the data bus. After every cycle the block leaves a programmable gap with all strobes high, so that the memory has released the bus before the next cycle starts.

Each timing window is a parameter counted in clock cycles. A zero value is raised to one cycle. All pin strobes come straight from flip-flops, so the memory never sees a decode glitch. The bidirectional data bus is modelled as separate input, output and output-enable signals. The controller drives the bus only while it writes.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `ready` is 1 and `rvalid` is 0.
- R2: A write request produces a strobe in which `sram_ce_n` and `sram_we_n` are both 0 for exactly `WR_PULSE_CYC` consecutive cycles (at least one), with `sram_oe_n` at 1 throughout.
- R3: During a write strobe, `sram_addr` and `sram_dq_out` hold the accepted address and data without change. `sram_dq_oe` is 1 for the whole strobe and for exactly one more cycle after the strobe ends, and is then 0.
- R4: `sram_dq_oe` is never 1 while `sram_oe_n` is 0, and `sram_addr` does not change while `sram_ce_n` stays 0.
- R5: A read request holds `sram_ce_n` and `sram_oe_n` at 0 and `sram_we_n` at 1 for exactly `RD_ACCESS_CYC` cycles. `rdata` takes the `sram_dq_in` value present at the end of the last of those cycles. `rvalid` is 1 for exactly one cycle, the first cycle after the strobes return high.
- R6: After a read the block waits `TURN_CYC` cycles, and after a write it waits one hold cycle plus `TURN_CYC` cycles, with all strobes high, before `ready` returns. The busy time seen at the port is therefore `RD_ACCESS_CYC+TURN_CYC` cycles for a read and `WR_PULSE_CYC+1+TURN_CYC` cycles for a write.
- R7: A request is taken only on a clock edge where `req` and `ready` are both 1 (`req_we`=1 selects a write, 0 a read). `ready` is 0 in the following cycle. A request presented while `ready` is 0 causes no pin activity and changes no memory content.
- R8: Data written to an address is returned unchanged by a later read of that address, for every address and for both a data pattern and its bitwise complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request valid |
| req_we | input | 1 | 1 selects write, 0 selects read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Block idle and able to take a request |
| rdata | output | DATA_W | Captured read data |
| rvalid | output | 1 | One-cycle pulse marking new `rdata` |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq_out | output | DATA_W | Data bus value driven by the controller |
| sram_dq_oe | output | 1 | Controller drives the data bus when 1 |
| sram_dq_in | input | DATA_W | Data bus value seen by the controller |

## Verification
The read-completion pulse can fall in the same cycle as a new request that is already waiting at the port. The bench creates this by holding `req` high across chains of back-to-back reads and writes, so that the next request is pending while `rvalid` fires for the previous one. It then checks four things: `rvalid` fires once at the expected busy cycle, `rdata` matches the behavioural memory, the waiting request starts only after the full turnaround gap, and the gap has the computed length. A second probe changes the address and data of a pending write while the block is busy and confirms through a later read that neither was used. The behavioural memory flags any write strobe shorter than the pulse parameter, any read that ends before the access time, and any bus contention.

// File: rtl/asram_ctrl_pkg.sv
// Package: shared phase encoding and parameter helpers for the SRAM sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package asram_ctrl_pkg;

    // Phases of one memory cycle
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_WRITE = 3'd1,
        PH_HOLD  = 3'd2,
        PH_READ  = 3'd3,
        PH_GAP   = 3'd4
    } phase_t;

    // Raise a cycle count to at least one
    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // Larger of two counts
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Module: down-counter that times the length of one phase.
// Assumes: load has priority; done is high while the count is zero.
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    assign done = (cnt_q == '0);

    // Load a new phase length or count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (!done) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/asram_sequencer.sv
// Module: phase state machine that produces registered SRAM strobes.
// Assumes: cycle counts are already at least one; the strobes come from flops
// loaded from the next phase, so each pin changes once per edge without glitches.
module asram_sequencer
    import asram_ctrl_pkg::*;
#(
    parameter int WR_CYC  = 1,
    parameter int RD_CYC  = 1,
    parameter int GAP_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic req_we,
    output logic ready,
    output logic accept,
    output logic capture,
    output logic ce_n,
    output logic we_n,
    output logic oe_n,
    output logic dq_oe
);

    localparam int MAX_CYC = max2(max2(WR_CYC, RD_CYC), GAP_CYC);
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    phase_t           state_q, state_d;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             done;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .done     (done)
    );

    assign ready   = (state_q == PH_IDLE);
    assign accept  = req && ready;
    assign capture = (state_q == PH_READ) && done;

    // Next phase and timer reload
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        case (state_q)
            PH_IDLE: begin
                if (req) begin
                    load = 1'b1;
                    if (req_we) begin
                        state_d  = PH_WRITE;
                        load_val = CNT_W'(WR_CYC - 1);
                    end else begin
                        state_d  = PH_READ;
                        load_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            PH_WRITE: begin
                if (done) state_d = PH_HOLD;
            end
            PH_HOLD: begin
                state_d  = PH_GAP;
                load     = 1'b1;
                load_val = CNT_W'(GAP_CYC - 1);
            end
            PH_READ: begin
                if (done) begin
                    state_d  = PH_GAP;
                    load     = 1'b1;
                    load_val = CNT_W'(GAP_CYC - 1);
                end
            end
            PH_GAP: begin
                if (done) state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Phase register and strobe flops decoded from the next phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            ce_n    <= 1'b1;
            we_n    <= 1'b1;
            oe_n    <= 1'b1;
            dq_oe   <= 1'b0;
        end else begin
            state_q <= state_d;
            ce_n    <= !((state_d == PH_WRITE) || (state_d == PH_READ));
            we_n    <= !(state_d == PH_WRITE);
            oe_n    <= !(state_d == PH_READ);
            dq_oe   <= (state_d == PH_WRITE) || (state_d == PH_HOLD);
        end
    end

    // Length of the current write-enable low run, used only by the check below
    logic [15:0] we_low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)     we_low_run <= '0;
        else if (!we_n) we_low_run <= we_low_run + 1'b1;
        else            we_low_run <= '0;
    end

    assert_strobe_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_low_run == 16'(WR_CYC)));

    assert_write_oe_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && !ce_n));

    assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);

    assert_idle_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ce_n && we_n && oe_n));

endmodule

// File: rtl/asram_datapath.sv
// Module: request capture and read-data return.
// Assumes: accept and capture come from the sequencer and never coincide.
module asram_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    // Hold address and write data for the whole memory cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            dq_out   <= req_wdata;
        end
    end

    // Sample the bus at the end of the access window and flag it for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) rdata <= dq_in;
        end
    end

    assert_rvalid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/asram_ctrl.sv
// Module: top of the asynchronous SRAM cycle sequencer.
// Assumes: timing parameters are cycle counts already derived from the clock
// period; zero or negative values are treated as one cycle.
module asram_ctrl
    import asram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int WR_PULSE_CYC  = 1,
    parameter int RD_ACCESS_CYC = 1,
    parameter int TURN_CYC      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int WR_EFF  = at_least_one(WR_PULSE_CYC);
    localparam int RD_EFF  = at_least_one(RD_ACCESS_CYC);
    localparam int GAP_EFF = at_least_one(TURN_CYC);

    logic accept;
    logic capture;

    asram_sequencer #(
        .WR_CYC  (WR_EFF),
        .RD_CYC  (RD_EFF),
        .GAP_CYC (GAP_EFF)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .req_we  (req_we),
        .ready   (ready),
        .accept  (accept),
        .capture (capture),
        .ce_n    (sram_ce_n),
        .we_n    (sram_we_n),
        .oe_n    (sram_oe_n),
        .dq_oe   (sram_dq_oe)
    );

    asram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (sram_dq_in),
        .mem_addr  (sram_addr),
        .dq_out    (sram_dq_out),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    assert_rvalid_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (sram_oe_n && $past(!sram_oe_n)));

endmodule

// File: tb/asram_ctrl_bench.sv
// Bench: behavioural SRAM plus an exhaustive address sweep on a 64-byte configuration.
module asram_ctrl_bench;

    localparam int AW  = 6;
    localparam int DW  = 8;
    localparam int WR  = 3;
    localparam int RD  = 2;
    localparam int GAP = 2;
    localparam int WR_BUSY = WR + 1 + GAP;
    localparam int RD_BUSY = RD + GAP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic          ready, rvalid;
    logic [DW-1:0] rdata;
    logic          ce_n, oe_n, we_n, dq_oe;
    logic [AW-1:0] mem_a;
    logic [DW-1:0] dq_out, dq_in;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    asram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .WR_PULSE_CYC(WR), .RD_ACCESS_CYC(RD), .TURN_CYC(GAP)
    ) u_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(we_i), .req_addr(addr_i),
        .req_wdata(wdata_i), .ready(ready), .rdata(rdata), .rvalid(rvalid),
        .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n), .sram_addr(mem_a),
        .sram_dq_out(dq_out), .sram_dq_oe(dq_oe), .sram_dq_in(dq_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural memory, observed mid-cycle
    logic [DW-1:0] mem [0:(1<<AW)-1];
    int            wr_seen = 0, rd_seen = 0, hold_left = 0, n_writes = 0;
    logic [AW-1:0] wr_a;
    logic [DW-1:0] wr_d;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ce_n && !we_n) begin
                if (wr_seen > 0) begin
                    chk(dq_out == wr_d, "R3 data stable", dq_out, wr_d);
                    chk(mem_a == wr_a, "R3 addr stable", mem_a, wr_a);
                end
                chk(oe_n == 1'b1, "R2 oe high in write", oe_n, 1);
                chk(dq_oe == 1'b1, "R3 bus driven in strobe", dq_oe, 1);
                wr_seen++;
                wr_d = dq_out;
                wr_a = mem_a;
            end else if (wr_seen > 0) begin
                chk(wr_seen == WR, "R2 strobe length", wr_seen, WR);
                chk(dq_oe == 1'b1, "R3 hold cycle", dq_oe, 1);
                mem[wr_a] = wr_d;
                n_writes++;
                wr_seen   = 0;
                hold_left = 1;
            end else if (hold_left > 0) begin
                chk(dq_oe == 1'b0, "R3 bus released", dq_oe, 0);
                hold_left = 0;
            end
            if (!ce_n && we_n && !oe_n) begin
                rd_seen++;
            end else if (rd_seen > 0) begin
                chk(rd_seen == RD, "R5 access length", rd_seen, RD);
                rd_seen = 0;
            end
            if (dq_oe && !oe_n) chk(1'b0, "R4 contention", 1, 0);
        end
    end

    assign dq_in = (!ce_n && we_n && !oe_n && rd_seen >= RD) ? mem[mem_a] : 8'h5A;

    function automatic logic [DW-1:0] pat(input int a, input bit inv);
        logic [DW-1:0] v;
        v = DW'(a * 37 + 5);
        return inv ? ~v : v;
    endfunction

    // One request; called and returning at a falling edge with ready high
    task automatic run_op(input logic w, input int a, input logic [DW-1:0] d, input bit keep,
                          output int busy, output int nval, output int vidx,
                          output logic [DW-1:0] rd);
        req = 1'b1; we_i = w; addr_i = AW'(a); wdata_i = d;
        while (!ready) @(negedge clk);
        @(negedge clk);
        if (!keep) req = 1'b0;
        busy = 0; nval = 0; vidx = 0; rd = '0;
        while (!ready) begin
            busy++;
            if (rvalid) begin nval++; vidx = busy; rd = rdata; end
            @(negedge clk);
        end
        if (rvalid) nval++;
    endtask

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", cyc, 100000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int busy, nval, vidx, wb;
        logic [DW-1:0] rd;
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state, during and just after reset
        chk(ce_n && we_n && oe_n, "R1 strobes in reset", {ce_n, we_n, oe_n}, 7);
        chk(!dq_oe && ready && !rvalid, "R1 port in reset", {dq_oe, ready, rvalid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ce_n && we_n && oe_n && !dq_oe, "R1 strobes after reset", {ce_n, we_n, oe_n, dq_oe}, 14);
        chk(ready && !rvalid, "R1 ready after reset", {ready, rvalid}, 2);

        for (int pass = 0; pass < 2; pass++) begin
            // R8 sweep: write every address, then read every address back
            for (int a = 0; a < (1 << AW); a++) begin
                run_op(1'b1, a, pat(a, pass[0]), 1'b0, busy, nval, vidx, rd);
                chk(busy == WR_BUSY, "R6 write busy", busy, WR_BUSY);
                chk(nval == 0, "R5 no rvalid on write", nval, 0);
            end
            for (int a = 0; a < (1 << AW); a++) begin
                run_op(1'b0, a, '0, 1'b0, busy, nval, vidx, rd);
                chk(busy == RD_BUSY, "R6 read busy", busy, RD_BUSY);
                chk(nval == 1, "R5 one rvalid", nval, 1);
                chk(vidx == RD + 1, "R5 rvalid cycle", vidx, RD + 1);
                chk(rd == pat(a, pass[0]), "R8 read back", rd, pat(a, pass[0]));
            end
        end

        // R7: change a pending request while busy and withdraw it before ready returns
        wb = n_writes;
        req = 1'b1; we_i = 1'b1; addr_i = AW'(5); wdata_i = 8'hC3;
        @(negedge clk);
        addr_i = AW'(6); wdata_i = 8'h3C;
        busy = 0;
        while (!ready) begin busy++; @(negedge clk); end
        req = 1'b0;
        chk(busy == WR_BUSY, "R7 busy with pending request", busy, WR_BUSY);
        repeat (3) @(negedge clk);
        chk(n_writes == wb + 1, "R7 single write", n_writes, wb + 1);
        chk(ce_n && we_n && oe_n, "R7 no pin activity after withdraw", {ce_n, we_n, oe_n}, 7);
        run_op(1'b0, 6, '0, 1'b0, busy, nval, vidx, rd);
        chk(rd == pat(6, 1'b1), "R7 pending data ignored", rd, pat(6, 1'b1));
        run_op(1'b0, 5, '0, 1'b0, busy, nval, vidx, rd);
        chk(rd == 8'hC3, "R7 accepted write", rd, 8'hC3);

        // rvalid coinciding with a waiting request: chained reads and writes with req held
        for (int k = 0; k < 8; k++) begin
            int a;
            a = (k * 9) % (1 << AW);
            run_op(1'b1, a, 8'(k * 17 + 1), 1'b1, busy, nval, vidx, rd);
            chk(busy == WR_BUSY, "R6 chained write busy", busy, WR_BUSY);
            run_op(1'b0, a, '0, 1'b1, busy, nval, vidx, rd);
            chk(busy == RD_BUSY, "R6 chained read busy", busy, RD_BUSY);
            chk(nval == 1 && vidx == RD + 1, "R5 chained rvalid", vidx, RD + 1);
            chk(rd == 8'(k * 17 + 1), "R8 chained data", rd, 8'(k * 17 + 1));
        end
        req = 1'b0;
        repeat (RD_BUSY + 2) @(negedge clk);
        chk(ready && ce_n, "R7 idle after chain", {ready, ce_n}, 3);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule